// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control Unit

This block is the steering logic of an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. The datapath reports, for every stage, the register numbers it reads or writes and a few class flags: load, conditional jump, return. For the execute stage it also reports the real outcome of the jump. From these the unit picks a source for each decode operand, holds or empties pipeline registers, and chooses where fetch takes its next address from.

ALU results reach a dependent decode operand in the next cycle, so they cost no stall. A load followed directly by a user of its result costs one decode hold, and the value then comes from the memory stage. Conditional jumps are assumed taken. If the execute stage finds the guess wrong, the two younger instructions are turned into bubbles, and one cycle later fetch is pointed at the fall-through address. A return holds fetch until it reaches writeback, where its target address becomes usable.

The only state is one flag. It remembers a wrong guess for one cycle and is cleared by a synchronous active-high reset. All other outputs follow the stage fields in the same cycle, because the pipeline registers they control sit in the datapath.

Top module: `hzd_ctrl`

## Requirements
- R1: When a decode operand equals the execute-stage destination and that instruction is not a load, the operand select is 1 (execute ALU result) and no stall or bubble is raised.
- R2: When the execute-stage instruction is a load whose destination equals any decode operand, f_stall=1, d_stall=1, e_bubble=1 and d_bubble=0. The operand select is never 1 for a load in execute.
- R3: When an operand matches the memory-stage destination, the select is 3 if that instruction is a load and 2 if it is not.
- R4: When several stages write the operand's register, the youngest wins: execute, then memory, then writeback (select 4), else register file (select 0).
- R5: Register number 4'hF (all ones) means "no register". It never matches, selects 0 and never causes a stall.
- R6: A conditional jump in execute with e_taken=0 raises d_bubble=1 and e_bubble=1 with no stall. A taken jump raises neither.
- R7: pc_sel is 1 (fall-through) in the cycle after a wrong guess, and that choice wins over a return in writeback. Otherwise, with no return in writeback, pc_sel is 0 (predicted path).
- R8: A return in decode, execute or memory gives f_stall=1 and d_bubble=1, with d_stall=0 and e_bubble=0.
- R9: A return in writeback gives pc_sel=2 (return address).
- R10: A wrong guess takes precedence: in that cycle f_stall=0 and d_stall=0, even when a load-use match or a return in decode is also present.
- R11: While reset is held, pc_sel is 0 even if a wrong guess is presented.
- R12: When a load-use match and a pending return occur together, the hold wins: d_stall=1 and d_bubble=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_src | input | NUM_SRC*REG_W | Decode operand registers, operand 0 in the low slice |
| d_is_ret | input | 1 | Decode holds a return |
| e_dst | input | REG_W | Execute destination register |
| e_is_load | input | 1 | Execute holds a load |
| e_is_jcc | input | 1 | Execute holds a conditional jump |
| e_taken | input | 1 | Real outcome of that jump |
| e_is_ret | input | 1 | Execute holds a return |
| m_dst | input | REG_W | Memory-stage destination register |
| m_is_load | input | 1 | Memory stage holds a load |
| m_is_ret | input | 1 | Memory stage holds a return |
| w_dst | input | REG_W | Writeback destination register |
| w_is_ret | input | 1 | Writeback holds a return |
| fwd_sel | output | NUM_SRC*3 | Operand source selects, operand 0 in the low slice |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a bubble into decode |
| e_bubble | output | 1 | Load a bubble into execute |
| pc_sel | output | 2 | Next fetch address: 0 predicted, 1 fall-through, 2 return |

## Verification
The hardest case to reach is several hazards at once. Examples are a wrong guess in the same cycle as a load-use match and a return in decode, or a load-use hold while a return is in flight. A well-formed program never produces these combinations, yet the priority among them still has to be defined. The bench drives each stage field on its own, so it can build such overlaps directly. The fall-through select depends on the previous cycle, so it is checked over pairs of vectors: a wrong guess followed by an idle vector or by a return in writeback, and a correct guess followed by an idle vector.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int FWD_W = 3;
  localparam int PC_W  = 2;

  typedef enum logic [FWD_W-1:0] {
    FWD_REG      = 3'd0,
    FWD_EXE      = 3'd1,
    FWD_MEM_ALU  = 3'd2,
    FWD_MEM_LOAD = 3'd3,
    FWD_WB       = 3'd4
  } hzd_fwd_e;

  typedef enum logic [PC_W-1:0] {
    PC_PREDICT  = 2'd0,
    PC_FALLTHRU = 2'd1,
    PC_RETADDR  = 2'd2
  } hzd_pc_e;
endpackage

// File: rtl/hzd_fwd_mux.sv
module hzd_fwd_mux
  import hzd_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] e_dst,
  input  logic             e_is_load,
  input  logic [REG_W-1:0] m_dst,
  input  logic             m_is_load,
  input  logic [REG_W-1:0] w_dst,
  output hzd_fwd_e         sel
);
  localparam logic [REG_W-1:0] NONE_ID = '1;

  // Youngest producer first; a load in execute has no value yet, so it is skipped
  always_comb begin
    sel = FWD_REG;
    if (src != NONE_ID) begin
      if ((src == e_dst) && !e_is_load) begin
        sel = FWD_EXE;
      end else if (src == m_dst) begin
        sel = m_is_load ? FWD_MEM_LOAD : FWD_MEM_ALU;
      end else if (src == w_dst) begin
        sel = FWD_WB;
      end
    end
  end

  AST_NO_BACKWARD_PATH: assert property (@(posedge clk) disable iff (rst) e_is_load |-> sel != FWD_EXE); // R2
  AST_NONE_READS_REGFILE: assert property (@(posedge clk) disable iff (rst) (src == NONE_ID) |-> sel == FWD_REG); // R5
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock #(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC*REG_W-1:0] d_src,
  input  logic                     d_is_ret,
  input  logic [REG_W-1:0]         e_dst,
  input  logic                     e_is_load,
  input  logic                     e_is_jcc,
  input  logic                     e_taken,
  input  logic                     e_is_ret,
  input  logic                     m_is_ret,
  output logic                     squash,
  output logic                     f_stall,
  output logic                     d_stall,
  output logic                     d_bubble,
  output logic                     e_bubble
);
  localparam logic [REG_W-1:0] NONE_ID = '1;

  logic [NUM_SRC-1:0] hit;
  logic               lu_raw;
  logic               load_use;
  logic               ret_busy;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
    assign hit[g] = (d_src[g*REG_W +: REG_W] == e_dst);
  end

  assign squash   = e_is_jcc && !e_taken;
  assign lu_raw   = e_is_load && (e_dst != NONE_ID) && (|hit);
  assign load_use = lu_raw && !squash;
  assign ret_busy = d_is_ret || e_is_ret || m_is_ret;

  always_comb begin
    f_stall  = !squash && (load_use || ret_busy);
    d_stall  = load_use;
    d_bubble = squash || (ret_busy && !load_use);
    e_bubble = squash || load_use;
  end

  AST_HOLD_IMPLIES_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst) d_stall |-> (f_stall && e_bubble)); // R2
  AST_SQUASH_NO_HOLD: assert property (@(posedge clk) disable iff (rst) (e_bubble && d_bubble) |-> !d_stall); // R10
  AST_HOLD_OR_BUBBLE: assert property (@(posedge clk) disable iff (rst) !(d_stall && d_bubble)); // R12
endmodule

// File: rtl/hzd_pc_select.sv
module hzd_pc_select
  import hzd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    squash,
  input  logic    w_is_ret,
  output hzd_pc_e pc_sel
);
  logic squash_q;

  // The wrong-guess jump always moves on to memory, so one flop marks that cycle
  always_ff @(posedge clk) begin
    if (rst) squash_q <= 1'b0;
    else     squash_q <= squash;
  end

  always_comb begin
    if (squash_q)      pc_sel = PC_FALLTHRU;
    else if (w_is_ret) pc_sel = PC_RETADDR;
    else               pc_sel = PC_PREDICT;
  end

  AST_FALLTHRU_NEXT: assert property (@(posedge clk) disable iff (rst) squash |=> pc_sel == PC_FALLTHRU); // R7
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC*REG_W-1:0] d_src,
  input  logic                     d_is_ret,
  input  logic [REG_W-1:0]         e_dst,
  input  logic                     e_is_load,
  input  logic                     e_is_jcc,
  input  logic                     e_taken,
  input  logic                     e_is_ret,
  input  logic [REG_W-1:0]         m_dst,
  input  logic                     m_is_load,
  input  logic                     m_is_ret,
  input  logic [REG_W-1:0]         w_dst,
  input  logic                     w_is_ret,
  output logic [NUM_SRC*FWD_W-1:0] fwd_sel,
  output logic                     f_stall,
  output logic                     d_stall,
  output logic                     d_bubble,
  output logic                     e_bubble,
  output logic [PC_W-1:0]          pc_sel
);
  hzd_fwd_e sel_w [NUM_SRC];
  hzd_pc_e  pc_w;
  logic     squash;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    hzd_fwd_mux #(.REG_W(REG_W)) i_fwd (
      .clk       (clk),
      .rst       (rst),
      .src       (d_src[g*REG_W +: REG_W]),
      .e_dst     (e_dst),
      .e_is_load (e_is_load),
      .m_dst     (m_dst),
      .m_is_load (m_is_load),
      .w_dst     (w_dst),
      .sel       (sel_w[g])
    );
    assign fwd_sel[g*FWD_W +: FWD_W] = sel_w[g];
  end

  hzd_interlock #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_lock (
    .clk       (clk),
    .rst       (rst),
    .d_src     (d_src),
    .d_is_ret  (d_is_ret),
    .e_dst     (e_dst),
    .e_is_load (e_is_load),
    .e_is_jcc  (e_is_jcc),
    .e_taken   (e_taken),
    .e_is_ret  (e_is_ret),
    .m_is_ret  (m_is_ret),
    .squash    (squash),
    .f_stall   (f_stall),
    .d_stall   (d_stall),
    .d_bubble  (d_bubble),
    .e_bubble  (e_bubble)
  );

  hzd_pc_select i_pc (
    .clk      (clk),
    .rst      (rst),
    .squash   (squash),
    .w_is_ret (w_is_ret),
    .pc_sel   (pc_w)
  );

  assign pc_sel = pc_w;

  AST_RESET_PREDICT: assert property (@(posedge clk) rst |=> (rst |-> pc_sel == PC_PREDICT)); // R11
endmodule

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;
  typedef struct {
    logic [3:0] src_a, src_b, e_dst, m_dst, w_dst;
    logic d_ret, e_load, e_jcc, e_taken, e_ret, m_load, m_ret, w_ret;
  } vec_t;

  typedef struct {
    logic [11:0] bits;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] d_src;
  logic d_is_ret, e_is_load, e_is_jcc, e_taken, e_is_ret, m_is_load, m_is_ret, w_is_ret;
  logic [3:0] e_dst, m_dst, w_dst;
  logic [5:0] fwd_sel;
  logic f_stall, d_stall, d_bubble, e_bubble;
  logic [1:0] pc_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  hzd_ctrl i_hzd_ctrl (
    .clk(clk), .rst(rst), .d_src(d_src), .d_is_ret(d_is_ret),
    .e_dst(e_dst), .e_is_load(e_is_load), .e_is_jcc(e_is_jcc), .e_taken(e_taken),
    .e_is_ret(e_is_ret), .m_dst(m_dst), .m_is_load(m_is_load), .m_is_ret(m_is_ret),
    .w_dst(w_dst), .w_is_ret(w_is_ret), .fwd_sel(fwd_sel), .f_stall(f_stall),
    .d_stall(d_stall), .d_bubble(d_bubble), .e_bubble(e_bubble), .pc_sel(pc_sel)
  );

  function automatic vec_t idle();
    vec_t v;
    v.src_a = 4'hF; v.src_b = 4'hF; v.e_dst = 4'hF; v.m_dst = 4'hF; v.w_dst = 4'hF;
    v.d_ret = 0; v.e_load = 0; v.e_jcc = 0; v.e_taken = 0; v.e_ret = 0;
    v.m_load = 0; v.m_ret = 0; v.w_ret = 0;
    return v;
  endfunction

  task automatic put(input vec_t v);
    d_src = {v.src_b, v.src_a};
    d_is_ret = v.d_ret; e_dst = v.e_dst; e_is_load = v.e_load; e_is_jcc = v.e_jcc;
    e_taken = v.e_taken; e_is_ret = v.e_ret; m_dst = v.m_dst; m_is_load = v.m_load;
    m_is_ret = v.m_ret; w_dst = v.w_dst; w_is_ret = v.w_ret;
  endtask

  // Driver: applies a vector and queues what the requirements predict for it
  task automatic run(input vec_t v, input logic [2:0] fa, input logic [2:0] fb,
                     input logic fs, input logic ds, input logic db, input logic eb,
                     input logic [1:0] pc, input string tag);
    exp_t x;
    @(negedge clk);
    put(v);
    x.bits = {fb, fa, fs, ds, db, eb, pc};
    x.tag = tag;
    sb.push_back(x);
  endtask

  // Monitor: compares outputs a little after inputs settle, well before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        logic [11:0] act;
        x = sb.pop_front();
        act = {fwd_sel, f_stall, d_stall, d_bubble, e_bubble, pc_sel};
        checks++;
        if (act !== x.bits) begin
          errors++;
          $display("FAIL %s: actual fb=%0d fa=%0d fs=%b ds=%b db=%b eb=%b pc=%0d expected fb=%0d fa=%0d fs=%b ds=%b db=%b eb=%b pc=%0d",
                   x.tag, act[11:9], act[8:6], act[5], act[4], act[3], act[2], act[1:0],
                   x.bits[11:9], x.bits[8:6], x.bits[5], x.bits[4], x.bits[3], x.bits[2], x.bits[1:0]);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    v = idle();
    v.e_jcc = 1; v.e_taken = 0;
    put(v);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    checks++;
    if (pc_sel !== 2'd0) begin
      errors++;
      $display("FAIL R11 reset: actual pc=%0d expected pc=0", pc_sel);
    end
    put(idle());
    rst = 1'b0;

    run(idle(), 0, 0, 0, 0, 0, 0, 0, "R5 idle");
    v = idle(); v.src_a = 1; v.src_b = 2; v.e_dst = 1;
    run(v, 1, 0, 0, 0, 0, 0, 0, "R1 alu from execute");
    v = idle(); v.src_a = 2; v.m_dst = 2; v.m_load = 1;
    run(v, 3, 0, 0, 0, 0, 0, 0, "R3 load value in memory");
    v = idle(); v.src_b = 5; v.m_dst = 5;
    run(v, 0, 2, 0, 0, 0, 0, 0, "R3 alu value in memory");
    v = idle(); v.src_a = 4; v.src_b = 4; v.e_dst = 4; v.m_dst = 4; v.w_dst = 4;
    run(v, 1, 1, 0, 0, 0, 0, 0, "R4 execute youngest");
    v = idle(); v.src_a = 6; v.src_b = 6; v.m_dst = 6; v.w_dst = 6;
    run(v, 2, 2, 0, 0, 0, 0, 0, "R4 memory over writeback");
    v = idle(); v.src_a = 6; v.w_dst = 6; v.src_b = 3; v.e_dst = 1; v.m_dst = 2;
    run(v, 4, 0, 0, 0, 0, 0, 0, "R4 writeback and regfile");
    v = idle(); v.src_a = 9; v.src_b = 2; v.e_dst = 2; v.e_load = 1;
    run(v, 0, 0, 1, 1, 0, 1, 0, "R2 load-use hold");
    v = idle(); v.e_load = 1; v.m_load = 1; v.w_dst = 4'hF;
    run(v, 0, 0, 0, 0, 0, 0, 0, "R5 none never matches");
    v = idle(); v.e_jcc = 1; v.e_taken = 0;
    run(v, 0, 0, 0, 0, 1, 1, 0, "R6 wrong guess squash");
    run(idle(), 0, 0, 0, 0, 0, 0, 1, "R7 fall-through next cycle");
    run(idle(), 0, 0, 0, 0, 0, 0, 0, "R7 back to predicted");
    v = idle(); v.e_jcc = 1; v.e_taken = 1;
    run(v, 0, 0, 0, 0, 0, 0, 0, "R6 correct guess");
    run(idle(), 0, 0, 0, 0, 0, 0, 0, "R7 no fall-through after correct guess");
    v = idle(); v.d_ret = 1;
    run(v, 0, 0, 1, 0, 1, 0, 0, "R8 return in decode");
    v = idle(); v.e_ret = 1;
    run(v, 0, 0, 1, 0, 1, 0, 0, "R8 return in execute");
    v = idle(); v.m_ret = 1;
    run(v, 0, 0, 1, 0, 1, 0, 0, "R8 return in memory");
    v = idle(); v.w_ret = 1;
    run(v, 0, 0, 0, 0, 0, 0, 2, "R9 return address");
    v = idle(); v.e_jcc = 1; v.e_taken = 0; v.d_ret = 1; v.e_load = 1; v.e_dst = 1; v.src_a = 1;
    run(v, 0, 0, 0, 0, 1, 1, 0, "R10 squash wins");
    v = idle(); v.w_ret = 1;
    run(v, 0, 0, 0, 0, 0, 0, 1, "R7 fall-through over return");
    v = idle(); v.src_a = 3; v.e_dst = 3; v.e_load = 1; v.m_ret = 1;
    run(v, 0, 0, 1, 1, 0, 1, 0, "R12 hold over return bubble");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule